// File: doc/BRIEF.md
# Grouped Interrupt Priority Controller

This block turns six interrupt request lines into one request strobe and a 3-bit index naming the source that wins. The six sources are fixed in three pairs: pair A holds sources 3 and 5, pair B holds sources 0 and 2, and pair C holds sources 1 and 4. A write-only priority register picks one of six orderings of the three pairs. It also holds one tie-break bit per pair that decides which member of that pair ranks higher.

Source 0 and source 2 are latched from two external pins. Each pin passes through a synchronizer and then an edge detector whose sensitivity is chosen by a 2-bit mode field. Sources 4 and 5 are set by one-cycle end-of-count pulses from two timers. Sources 1 and 3 are set only by software writes to the pending register, which software can read and write. A mask register holds one enable bit per source and a global enable bit.

The strobe and index are registered outputs. While the strobe is high, the index does not change. Pulsing the acknowledge input clears the pending bit of the reported source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the strobe is low, the pending register reads 00h and the mask register reads 00h. The global enable is therefore 0, and the priority register holds group code 000.
- R2: The priority register is laid out as follows:
  - bits 2:0 hold the group code;
  - bit 3 is the pair A select, bit 4 the pair B select, and bit 5 the pair C select.

  The pairs are ranked by the group code: 001 gives C>A>B, 010 gives A>B>C, 011 gives A>C>B, 100 gives B>C>A, 101 gives C>B>A, and 110 gives B>A>C. The index reports the highest-ranked source that is both pending and enabled.
- R3: Within a pair, the select bit decides which member ranks higher:
  - pair A: 0 ranks source 5 above source 3, and 1 ranks source 3 above source 5;
  - pair B: 0 ranks source 2 above source 0, and 1 reverses that;
  - pair C: 0 ranks source 1 above source 4, and 1 reverses that.
- R4: Group codes 000 and 111 are reserved. While either is loaded, the strobe stays low.
- R5: In the mask register, bits 5:0 enable sources 5..0, with bit 0 for source 0, and bit 7 is the global enable. Bit 6 reads 0. The strobe is high only when the global enable is 1 and at least one pending bit is enabled.
- R6: Bits 7:6 of the pending register form a mode field that sets the edge sensitivity of both pins:
  - the source-2 pin sets its flag on a falling edge for modes 00 and 01, on a rising edge for mode 10, and on both edges for mode 11;
  - the source-0 pin sets its flag on a falling edge for modes 00 and 10, on a rising edge for mode 01, and on both edges for mode 11.
- R7: A one-cycle pulse on the first timer input sets pending bit 4. A one-cycle pulse on the second timer input sets pending bit 5.
- R8: A write to the pending register replaces bits 5:0 and the mode field. A hardware set that arrives in the same cycle as the write still sets its bit.
- R9: Acknowledge, given while the strobe is high, clears the pending bit of the reported index at that clock edge.
- R10: While the strobe is high, the index holds its value even when a higher-ranked source becomes pending. The index is re-evaluated once the reported source is acknowledged.
- R11: Bits 7:6 of a priority-register write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 1 | External pin that sets source 0 |
| pin_b | input | 1 | External pin that sets source 2 |
| tmr0_done | input | 1 | Timer pulse that sets source 4 |
| tmr1_done | input | 1 | Timer pulse that sets source 5 |
| req_wr | input | 1 | Write strobe for the pending register |
| mask_wr | input | 1 | Write strobe for the mask register |
| prio_wr | input | 1 | Write strobe for the priority register |
| wdata | input | DATA_W | Write data shared by the three registers |
| req_rdata | output | DATA_W | Pending register readback: mode field and pending bits |
| mask_rdata | output | DATA_W | Mask register readback |
| ack | input | 1 | Acknowledge of the reported source |
| irq_out | output | 1 | Interrupt request strobe |
| irq_idx | output | 3 | Index of the winning source |

## Verification
The bench sweeps all eight group codes against all eight select combinations and all 63 nonzero pending patterns. A resolver that swapped two pairs' ranks, or inverted one tie-break bit, would report the wrong index in many of these cases. A resolver that did not gate the reserved codes would raise the strobe for codes 000 and 111.

The bench also walks every mode code on both pins, in both edge directions, because the two pins decode the mode field differently. It then tests three timing cases:
- an index that must stay put while a higher-ranked source arrives;
- an acknowledge that must clear exactly the reported bit;
- a timer pulse that coincides with a software write that clears the register, which a write-wins design would lose.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   localparam int SRC_N = 6;
   localparam int IDX_W = 3;

   // priority register content kept by the block (bits 5:0 of a write)
   typedef struct packed {
      logic       sel_c;
      logic       sel_b;
      logic       sel_a;
      logic [2:0] order;
   } prio_cfg_t;

   function automatic logic order_ok(input logic [2:0] code);
      return (code != 3'b000) && (code != 3'b111);
   endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_en,
   input  logic fall_en,
   output logic pulse
);

   localparam int HIST = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [HIST-1:0] sh_q;
   logic            cur, prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[HIST-2:0], pin};
   end

   assign cur   = sh_q[SYNC_STAGES-1];
   assign prev  = sh_q[SYNC_STAGES];
   assign pulse = (cur & ~prev & rise_en) | (~cur & prev & fall_en);

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
   import irq_prio_pkg::*;
(
   input  logic [SRC_N-1:0] eff,
   input  prio_cfg_t        cfg,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);

   localparam int GRP_N = 3;
   // per pair (A,B,C at slots 0,1,2): member that wins when its select bit is 1
   localparam logic [3*GRP_N-1:0] MEM_SEL1 = {3'd4, 3'd0, 3'd3};
   // member that wins when its select bit is 0
   localparam logic [3*GRP_N-1:0] MEM_SEL0 = {3'd1, 3'd2, 3'd5};

   logic [GRP_N-1:0] sel_vec;
   logic [GRP_N-1:0] g_hit;
   logic [IDX_W-1:0] g_pick [GRP_N];
   logic [1:0]       rank   [GRP_N];

   assign sel_vec = {cfg.sel_c, cfg.sel_b, cfg.sel_a};

   for (genvar g = 0; g < GRP_N; g++) begin : g_pair
      logic [IDX_W-1:0] hi, lo;
      assign hi        = sel_vec[g] ? MEM_SEL1[g*3 +: 3] : MEM_SEL0[g*3 +: 3];
      assign lo        = sel_vec[g] ? MEM_SEL0[g*3 +: 3] : MEM_SEL1[g*3 +: 3];
      assign g_hit[g]  = eff[hi] | eff[lo];
      assign g_pick[g] = eff[hi] ? hi : lo;
   end

   always_comb begin
      case (cfg.order)
         3'b001:  begin rank[0] = 2'd2; rank[1] = 2'd0; rank[2] = 2'd1; end
         3'b010:  begin rank[0] = 2'd0; rank[1] = 2'd1; rank[2] = 2'd2; end
         3'b011:  begin rank[0] = 2'd0; rank[1] = 2'd2; rank[2] = 2'd1; end
         3'b100:  begin rank[0] = 2'd1; rank[1] = 2'd2; rank[2] = 2'd0; end
         3'b101:  begin rank[0] = 2'd2; rank[1] = 2'd1; rank[2] = 2'd0; end
         3'b110:  begin rank[0] = 2'd1; rank[1] = 2'd0; rank[2] = 2'd2; end
         default: begin rank[0] = 2'd0; rank[1] = 2'd1; rank[2] = 2'd2; end
      endcase
   end

   always_comb begin
      idx = '0;
      for (int k = GRP_N - 1; k >= 0; k--) begin
         if (g_hit[rank[k]]) idx = g_pick[rank[k]];
      end
      valid = order_ok(cfg.order) && (|g_hit);
   end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_prio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_a,
   input  logic              pin_b,
   input  logic              tmr0_done,
   input  logic              tmr1_done,
   input  logic              req_wr,
   input  logic              mask_wr,
   input  logic              prio_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] req_rdata,
   output logic [DATA_W-1:0] mask_rdata,
   input  logic              ack,
   output logic              irq_out,
   output logic [IDX_W-1:0]  irq_idx
);

   localparam int GEN_BIT  = DATA_W - 1;
   localparam int MODE_TOP = DATA_W - 1;
   localparam int PAD_W    = 1 << IDX_W;

   if (DATA_W != 8) begin : g_bad_width
      $error("irq_prio_ctrl: DATA_W must be 8");
   end

   logic [SRC_N-1:0] pend_q, en_q, pend_n, en_n, eff_n, hw_set, ack_clr, base;
   logic [1:0]       mode_q, mode_n;
   logic             gen_q, gen_n;
   prio_cfg_t        prio_q, prio_n;
   logic             edge_a, edge_b, win_valid, hold_ok;
   logic [IDX_W-1:0] win_idx;
   logic [PAD_W-1:0] eff_pad, pend_pad;

   // pin A (source 0) and pin B (source 2) edge enables from the mode field
   logic [1:0] pin_vec, rise_vec, fall_vec, pulse_vec;
   assign pin_vec  = {pin_b, pin_a};
   assign rise_vec = {mode_q[1], mode_q[0]};
   assign fall_vec = {~mode_q[1] | mode_q[0], mode_q[1] | ~mode_q[0]};

   for (genvar p = 0; p < 2; p++) begin : g_pin
      irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (pin_vec[p]),
         .rise_en (rise_vec[p]),
         .fall_en (fall_vec[p]),
         .pulse   (pulse_vec[p])
      );
   end
   assign edge_a = pulse_vec[0];
   assign edge_b = pulse_vec[1];

   assign hw_set = {tmr1_done, tmr0_done, 1'b0, edge_b, 1'b0, edge_a};

   always_comb begin
      ack_clr = '0;
      if (ack && irq_out) ack_clr[irq_idx] = 1'b1;
      base    = req_wr ? wdata[SRC_N-1:0] : pend_q;
      pend_n  = (base & ~ack_clr) | hw_set;
      mode_n  = req_wr ? wdata[MODE_TOP -: 2] : mode_q;
      en_n    = mask_wr ? wdata[SRC_N-1:0] : en_q;
      gen_n   = mask_wr ? wdata[GEN_BIT] : gen_q;
      prio_n  = prio_wr ? prio_cfg_t'(wdata[SRC_N-1:0]) : prio_q;
      eff_n   = pend_n & en_n & {SRC_N{gen_n}};
   end

   irq_prio_resolve u_res (
      .eff   (eff_n),
      .cfg   (prio_n),
      .valid (win_valid),
      .idx   (win_idx)
   );

   assign eff_pad = PAD_W'(eff_n);
   assign hold_ok = irq_out && !ack && eff_pad[irq_idx] && order_ok(prio_n.order);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         mode_q  <= '0;
         en_q    <= '0;
         gen_q   <= 1'b0;
         prio_q  <= '0;
         irq_out <= 1'b0;
         irq_idx <= '0;
      end else begin
         pend_q <= pend_n;
         mode_q <= mode_n;
         en_q   <= en_n;
         gen_q  <= gen_n;
         prio_q <= prio_n;
         if (!hold_ok) begin
            irq_out <= win_valid;
            irq_idx <= win_idx;
         end
      end
   end

   always_comb begin
      req_rdata                 = '0;
      req_rdata[SRC_N-1:0]      = pend_q;
      req_rdata[MODE_TOP -: 2]  = mode_q;
      mask_rdata                = '0;
      mask_rdata[SRC_N-1:0]     = en_q;
      mask_rdata[GEN_BIT]       = gen_q;
   end

   assign pend_pad = PAD_W'(pend_q);

   // reserved group code with no priority write keeps the strobe low
   assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!prio_wr && !order_ok(prio_q.order)) |=> !irq_out);

   // a raised strobe always has global enable and an enabled pending source
   assert_strobe_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (gen_q && |(pend_q & en_q)));

   // the reported index is a real source number
   assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_idx < IDX_W'(SRC_N)));

   // acknowledge removes the reported bit unless hardware sets it again
   assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && ack && !req_wr && !hw_set[irq_idx]) |=> !pend_pad[$past(irq_idx)]);

   // with no acknowledge and no register writes, the index stays put
   assert_idx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ack && !req_wr && !mask_wr && !prio_wr)
      |=> (irq_out && irq_idx == $past(irq_idx)));

endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_a = 1'b0, pin_b = 1'b0, tmr0_done = 1'b0, tmr1_done = 1'b0;
   logic       req_wr = 1'b0, mask_wr = 1'b0, prio_wr = 1'b0, ack = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] req_rdata, mask_rdata;
   logic       irq_out;
   logic [2:0] irq_idx;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   irq_prio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
      .tmr0_done(tmr0_done), .tmr1_done(tmr1_done),
      .req_wr(req_wr), .mask_wr(mask_wr), .prio_wr(prio_wr), .wdata(wdata),
      .req_rdata(req_rdata), .mask_rdata(mask_rdata),
      .ack(ack), .irq_out(irq_out), .irq_idx(irq_idx)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int which, input logic [7:0] d);
      @(negedge clk);
      wdata = d;
      req_wr  = (which == 0);
      mask_wr = (which == 1);
      prio_wr = (which == 2);
      @(negedge clk);
      req_wr = 0; mask_wr = 0; prio_wr = 0;
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack = 1;
      @(negedge clk);
      ack = 0;
   endtask

   // model of the requirement tables: -1 means no strobe
   function automatic int exp_idx(input int eff, input int code, input int sel);
      int ord[3];
      int g, hi, lo;
      case (code)
         1: ord = '{2, 0, 1};
         2: ord = '{0, 1, 2};
         3: ord = '{0, 2, 1};
         4: ord = '{1, 2, 0};
         5: ord = '{2, 1, 0};
         6: ord = '{1, 0, 2};
         default: return -1;
      endcase
      for (int k = 0; k < 3; k++) begin
         g = ord[k];
         if (g == 0) begin hi = sel[0] ? 3 : 5; lo = sel[0] ? 5 : 3; end
         else if (g == 1) begin hi = sel[1] ? 0 : 2; lo = sel[1] ? 2 : 0; end
         else begin hi = sel[2] ? 4 : 1; lo = sel[2] ? 1 : 4; end
         if ((eff >> hi) & 1) return hi;
         if ((eff >> lo) & 1) return lo;
      end
      return -1;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int e;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 strobe", int'(irq_out), 0);
      check("R1 pending", int'(req_rdata), 0);
      check("R1 mask", int'(mask_rdata), 0);
      wr(0, 8'h3f);
      check("R1 code 000 quiet", int'(irq_out), 0);
      wr(0, 8'h00);

      // R2 / R3 / R4 full sweep
      wr(1, 8'hbf);
      check("R5 mask readback bit6 zero", int'(mask_rdata), 8'hbf);
      for (int c = 0; c < 8; c++) begin
         for (int s = 0; s < 8; s++) begin
            wr(2, 8'(s * 8 + c));
            for (int p = 1; p < 64; p++) begin
               wr(0, 8'h00);
               wr(0, 8'(p));
               e = exp_idx(p, c, s);
               if (e < 0) check("R4 reserved quiet", int'(irq_out), 0);
               else begin
                  check("R2 strobe", int'(irq_out), 1);
                  check("R3 R2 index", int'(irq_idx), e);
               end
            end
         end
      end

      // R11 upper priority bits ignored
      wr(2, 8'hc0 | 8'(5 * 8 + 3));
      wr(0, 8'h00);
      wr(0, 8'h37);
      check("R11 strobe", int'(irq_out), 1);
      check("R11 index", int'(irq_idx), exp_idx(8'h37, 3, 5));

      // R5 mask and global enable sweep
      wr(2, 8'h02);
      for (int g = 0; g < 2; g++) begin
         for (int m = 0; m < 64; m++) begin
            wr(0, 8'h00);
            wr(1, 8'(g * 128 + m));
            wr(0, 8'h3f);
            check("R5 strobe", int'(irq_out), (g == 1 && m != 0) ? 1 : 0);
            if (g == 1 && m != 0) check("R5 index", int'(irq_idx), exp_idx(m, 2, 0));
         end
      end
      wr(0, 8'h00);
      wr(1, 8'hbf);

      // R6 edge modes on both pins
      for (int md = 0; md < 4; md++) begin
         for (int pn = 0; pn < 2; pn++) begin
            int bitp, rise, fall;
            bitp = pn ? 2 : 0;
            if (pn == 0) begin rise = md & 1; fall = (md == 1) ? 0 : 1; end
            else begin rise = (md >> 1) & 1; fall = (md == 2) ? 0 : 1; end
            wr(0, 8'(md << 6));
            @(negedge clk);
            if (pn) pin_b = 1; else pin_a = 1;
            repeat (5) @(negedge clk);
            check("R6 rising", int'(req_rdata[bitp]), rise);
            wr(0, 8'(md << 6));
            @(negedge clk);
            if (pn) pin_b = 0; else pin_a = 0;
            repeat (5) @(negedge clk);
            check("R6 falling", int'(req_rdata[bitp]), fall);
            check("R8 mode readback", int'(req_rdata[7:6]), md);
         end
      end
      wr(0, 8'h00);

      // R7 timer pulses
      @(negedge clk); tmr0_done = 1;
      @(negedge clk); tmr0_done = 0;
      check("R7 timer0 sets bit4", int'(req_rdata), 8'h10);
      @(negedge clk); tmr1_done = 1;
      @(negedge clk); tmr1_done = 0;
      check("R7 timer1 sets bit5", int'(req_rdata), 8'h30);

      // R8 write and hardware set in the same cycle
      @(negedge clk);
      wdata = 8'h01; req_wr = 1; tmr1_done = 1;
      @(negedge clk);
      req_wr = 0; tmr1_done = 0;
      check("R8 write plus timer", int'(req_rdata), 8'h21);
      @(negedge clk);
      wdata = 8'h00; req_wr = 1; tmr0_done = 1;
      @(negedge clk);
      req_wr = 0; tmr0_done = 0;
      check("R8 clear write loses to timer", int'(req_rdata), 8'h10);
      wr(0, 8'h00);

      // R9 acknowledge; code 010 A>B>C, selects 0
      wr(2, 8'h02);
      wr(0, 8'h21);
      check("R9 first index", int'(irq_idx), 5);
      pulse_ack();
      check("R9 bit cleared", int'(req_rdata), 8'h01);
      check("R9 next index", int'(irq_idx), 0);
      pulse_ack();
      check("R9 all clear", int'(req_rdata), 0);
      check("R9 strobe low", int'(irq_out), 0);

      // R10 index hold
      wr(0, 8'h02);
      check("R10 low source shown", int'(irq_idx), 1);
      @(negedge clk); tmr1_done = 1;
      @(negedge clk); tmr1_done = 0;
      repeat (2) @(negedge clk);
      check("R10 index held", int'(irq_idx), 1);
      check("R10 strobe held", int'(irq_out), 1);
      pulse_ack();
      check("R10 moves after ack", int'(irq_idx), 5);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule